// File: doc/BRIEF.md
# Nonvolatile Commit Sequencer with Busy Hold-off

This block copies three live setting registers into nonvolatile storage once a write transaction on the serial control bus has ended. A one-cycle pulse from the bus engine marks the STOP that closes a write. If the configuration selects nonvolatile mode at that moment, the block takes a snapshot of the three live values. It can then wait for a zero-crossing-complete indication. After that it issues one write strobe per storage location and runs a fixed write-time counter.

For the whole sequence the block raises a busy flag. The bus engine uses this flag to refuse its own address with a NACK, so a host can poll for ready. In volatile mode the STOP is still accepted, but no storage activity follows. The storage port is abstract: a one-hot strobe per location and a shared data bus.

Top module: `nv_commit_ctrl`

## Requirements
- R1: When `busy_o` is low and `stop_wr_i` is sampled high together with `nv_mode_i` high, `busy_o` is high in the following cycle.
- R2: When `stop_wr_i` is sampled high with `nv_mode_i` low, `busy_o` stays low and `nv_we_o` stays all-zero.
- R3: Every commit writes all three locations, in the order 0, 1, 2, on three consecutive cycles. At most one strobe is active per cycle. Bit i of `nv_we_o` selects location i, and `nv_wdata_o` then carries the value captured from `live_regs_i[i*8 +: 8]`.
- R4: With `zc_en_i` low at the STOP, the location-0 strobe appears in the cycle after the STOP. With `zc_en_i` high, no strobe appears until `zc_done_i` has been sampled high, and the location-0 strobe appears in the cycle after that.
- R5: After the location-2 strobe, `busy_o` stays high for exactly TW_CYCLES further cycles and then drops to low.
- R6: The values written are the ones present on `live_regs_i` at the STOP edge. Changes to `live_regs_i` afterwards do not alter them.
- R7: A `stop_wr_i` pulse that arrives while `busy_o` is high is ignored. It adds no strobe and does not change when `busy_o` falls.
- R8: During and just after a synchronous reset, `busy_o` is low and `nv_we_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_wr_i | input | 1 | One-cycle pulse: STOP ending a write transaction |
| nv_mode_i | input | 1 | Configuration bit: 1 selects nonvolatile storage |
| zc_en_i | input | 1 | Zero-crossing gating enabled |
| zc_done_i | input | 1 | Zero-crossing detection complete |
| live_regs_i | input | NUM_LOC*DATA_W | Live register values, location i at bits [i*DATA_W +: DATA_W] |
| busy_o | output | 1 | Commit in progress; the bus engine NACKs its address |
| nv_we_o | output | NUM_LOC | One-hot write strobe per storage location |
| nv_wdata_o | output | DATA_W | Data for the strobed location |

## Verification
The hardest case to reach is a second STOP that lands while a commit is already in flight. A correct bus engine never produces one, because the block's own busy flag makes it NACK the address. The bench drives `stop_wr_i` directly in the middle of the strobe phase and again during the write time, then checks that the strobe count and the exact cycle at which busy falls are unchanged. The same runs replace the live inputs with inverted values right after the STOP, so that a missing snapshot shows up as wrong data. The zero-crossing wait length is swept from one to four cycles.

// File: rtl/nv_commit_pkg.sv
package nv_commit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_ZC = 2'd1,
    ST_WRITE   = 2'd2,
    ST_WAIT_TW = 2'd3
  } nv_state_e;
endpackage

// File: rtl/nv_snapshot.sv
module nv_snapshot #(
  parameter int DATA_W  = 8,
  parameter int NUM_LOC = 3,
  localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cap_i,
  input  logic                      hold_i,
  input  logic [NUM_LOC*DATA_W-1:0] live_i,
  input  logic [LOC_W-1:0]          sel_i,
  output logic [DATA_W-1:0]         data_o
);
  logic [DATA_W-1:0] snap_q [NUM_LOC];

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    always_ff @(posedge clk) begin
      if (rst) begin
        snap_q[g] <= '0;
      end else if (cap_i) begin
        snap_q[g] <= live_i[g*DATA_W +: DATA_W];
      end
    end

    // R6: the captured copy holds still for the whole commit
    a_r6_snap_stable: assert property (@(posedge clk) disable iff (rst)
      (hold_i && !cap_i) |=> $stable(snap_q[g]));
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (sel_i == LOC_W'(i)) data_o = snap_q[i];
    end
  end
endmodule

// File: rtl/nv_tw_timer.sv
module nv_tw_timer #(
  parameter int TW_CYCLES = 1000,
  localparam int CNT_W = (TW_CYCLES > 1) ? $clog2(TW_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(TW_CYCLES - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);

  // R5: a running count steps down by one each cycle
  a_r5_timer_steps: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q != '0 && !start_i) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nv_seq_fsm.sv
module nv_seq_fsm
  import nv_commit_pkg::*;
#(
  parameter int NUM_LOC = 3,
  localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_wr_i,
  input  logic               nv_mode_i,
  input  logic               zc_en_i,
  input  logic               zc_done_i,
  input  logic               tw_done_i,
  output logic               cap_o,
  output logic               tw_start_o,
  output logic               busy_o,
  output logic               write_o,
  output logic [LOC_W-1:0]   loc_o
);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_LOC - 1);

  nv_state_e        state_q, state_d;
  logic [LOC_W-1:0] loc_q;

  always_comb begin
    state_d    = state_q;
    cap_o      = 1'b0;
    tw_start_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (stop_wr_i && nv_mode_i) begin
          cap_o   = 1'b1;
          state_d = zc_en_i ? ST_WAIT_ZC : ST_WRITE;
        end
      end
      ST_WAIT_ZC: if (zc_done_i) state_d = ST_WRITE;
      ST_WRITE: begin
        if (loc_q == LAST_LOC) begin
          state_d    = ST_WAIT_TW;
          tw_start_o = 1'b1;
        end
      end
      ST_WAIT_TW: if (tw_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      loc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WRITE && loc_q != LAST_LOC) loc_q <= loc_q + 1'b1;
      else                                          loc_q <= '0;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign write_o = (state_q == ST_WRITE);
  assign loc_o   = loc_q;

  // R4: no storage write while waiting for the zero crossing
  a_r4_zc_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_ZC && !zc_done_i) |=> !write_o);
  // R7: a STOP while busy never restarts the capture
  a_r7_no_recapture: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !cap_o);
  // R3: the write phase always runs through its locations in order
  a_r3_loc_order: assert property (@(posedge clk) disable iff (rst)
    (write_o && loc_q != LAST_LOC) |=> (write_o && loc_q == $past(loc_q) + 1'b1));
endmodule

// File: rtl/nv_commit_ctrl.sv
module nv_commit_ctrl #(
  parameter int DATA_W    = 8,
  parameter int NUM_LOC   = 3,
  parameter int TW_CYCLES = 1000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      stop_wr_i,
  input  logic                      nv_mode_i,
  input  logic                      zc_en_i,
  input  logic                      zc_done_i,
  input  logic [NUM_LOC*DATA_W-1:0] live_regs_i,
  output logic                      busy_o,
  output logic [NUM_LOC-1:0]        nv_we_o,
  output logic [DATA_W-1:0]         nv_wdata_o
);
  localparam int LOC_W = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;

  logic             cap, tw_start, tw_done, writing;
  logic [LOC_W-1:0] loc;

  nv_seq_fsm #(.NUM_LOC(NUM_LOC)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .stop_wr_i  (stop_wr_i),
    .nv_mode_i  (nv_mode_i),
    .zc_en_i    (zc_en_i),
    .zc_done_i  (zc_done_i),
    .tw_done_i  (tw_done),
    .cap_o      (cap),
    .tw_start_o (tw_start),
    .busy_o     (busy_o),
    .write_o    (writing),
    .loc_o      (loc)
  );

  nv_snapshot #(.DATA_W(DATA_W), .NUM_LOC(NUM_LOC)) u_snap (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (cap),
    .hold_i (busy_o),
    .live_i (live_regs_i),
    .sel_i  (loc),
    .data_o (nv_wdata_o)
  );

  nv_tw_timer #(.TW_CYCLES(TW_CYCLES)) u_tw (
    .clk     (clk),
    .rst     (rst),
    .start_i (tw_start),
    .done_o  (tw_done)
  );

  always_comb begin
    nv_we_o = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (writing && loc == LOC_W'(i)) nv_we_o[i] = 1'b1;
    end
  end

  // R3: at most one location strobed per cycle
  a_r3_onehot_we: assert property (@(posedge clk) disable iff (rst)
    $onehot0(nv_we_o));
  // R3: strobes only happen inside a busy period
  a_r3_we_busy: assert property (@(posedge clk) disable iff (rst)
    (|nv_we_o) |-> busy_o);
  // R1: a nonvolatile STOP from idle raises busy
  a_r1_start: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && stop_wr_i && nv_mode_i) |=> busy_o);
  // R2: a volatile STOP from idle leaves the block idle
  a_r2_volatile: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && stop_wr_i && !nv_mode_i) |=> (!busy_o && nv_we_o == '0));
endmodule

// File: tb/nv_commit_ctrl_bench.sv
module nv_commit_ctrl_bench;
  localparam int DW = 8;
  localparam int NL = 3;
  localparam int TW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_wr = 1'b0, nv_mode = 1'b0, zc_en = 1'b0, zc_done = 1'b0;
  logic [NL*DW-1:0] live = '0;
  logic busy;
  logic [NL-1:0] we;
  logic [DW-1:0] wdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  nv_commit_ctrl #(.DATA_W(DW), .NUM_LOC(NL), .TW_CYCLES(TW)) u_nv_commit_ctrl (
    .clk(clk), .rst(rst), .stop_wr_i(stop_wr), .nv_mode_i(nv_mode),
    .zc_en_i(zc_en), .zc_done_i(zc_done), .live_regs_i(live),
    .busy_o(busy), .nv_we_o(we), .nv_wdata_o(wdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  // One nonvolatile commit; poke inserts stray STOPs while busy (R7)
  task automatic commit(input bit zen, input int zdly, input logic [NL*DW-1:0] d, input bit poke);
    @(negedge clk);
    stop_wr = 1'b1; nv_mode = 1'b1; zc_en = zen; zc_done = 1'b0; live = d;
    @(negedge clk);
    stop_wr = 1'b0;
    live = ~d; // R6: later changes must not reach storage
    check(busy === 1'b1, "R1 busy after STOP", int'(busy), 1);
    if (zen) begin
      for (int i = 0; i <= zdly; i++) begin
        check(busy === 1'b1 && we === '0, "R4 hold for zero crossing", int'(we), 0);
        if (i == zdly) zc_done = 1'b1;
        @(negedge clk);
        zc_done = 1'b0;
      end
    end
    for (int l = 0; l < NL; l++) begin
      check(we === NL'(1 << l), "R3 strobe order", int'(we), 1 << l);
      check(wdata === d[l*DW +: DW], "R6 captured data", int'(wdata), int'(d[l*DW +: DW]));
      if (poke && l == 1) stop_wr = 1'b1;
      @(negedge clk);
      stop_wr = 1'b0;
    end
    for (int t = 0; t < TW; t++) begin
      check(busy === 1'b1 && we === '0, "R5 busy during write time", int'(busy), 1);
      if (poke && t == 1) stop_wr = 1'b1; // R7
      @(negedge clk);
      stop_wr = 1'b0;
    end
    check(busy === 1'b0, "R5 busy clears after write time", int'(busy), 0);
    check(we === '0, "R7 no extra strobe", int'(we), 0);
    @(negedge clk);
    check(busy === 1'b0 && we === '0, "R7 stays idle", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && we === '0, "R8 reset state", int'(busy), 0);
    @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && we === '0, "R8 after reset", int'(we), 0);

    // R2: volatile STOPs do nothing
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      stop_wr = 1'b1; nv_mode = 1'b0; zc_en = k[0]; live = 24'hA5A5A5;
      @(negedge clk);
      stop_wr = 1'b0;
      for (int c = 0; c < 4; c++) begin
        check(busy === 1'b0 && we === '0, "R2 volatile STOP ignored", int'(busy), 0);
        @(negedge clk);
      end
    end

    // Sweep: zero-crossing gating off and on with wait lengths 0..3
    for (int z = 0; z < 5; z++) begin
      for (int p = 0; p < 2; p++) begin
        logic [NL*DW-1:0] d;
        for (int l = 0; l < NL; l++) d[l*DW +: DW] = DW'(z * 53 + p * 29 + l * 71 + 7);
        commit(z != 0, (z == 0) ? 0 : z - 1, d, p == 1);
      end
    end

    // Data pattern sweep with single-bit and all-ones values
    for (int b = 0; b < DW; b++) begin
      commit(1'b0, 0, {DW'(1 << b), ~DW'(1 << b), DW'(8'hFF >> b)}, b[0]);
    end

    finish_run();
  end
endmodule